// File: doc/BRIEF.md
# Byte-Exchange Link Port Controller

This block lets a processor swap a single byte with a partner unit across a point-to-point link. Software writes the outgoing byte into a transmit register, which is presented to the partner continuously. It then starts a transfer through the control register. When the transfer ends, the byte the partner offers lands in the local receive register, the busy flag drops, and an interrupt is raised unless software has masked it.

The unit runs in one of two timing modes. With internal timing it counts a fixed transfer time itself: 3200 clocks by default, which is 160 us at 20 MHz. With external timing it waits for a completion strobe from the partner that drives the link clock. The whole byte is exchanged at once. Serialisation on the wire is not modelled.

The interrupt output is the OR of this block's transfer flag and a companion signal-line interrupt input. All outputs are registered.

Top module: `link_xchg_ctrl`

## Requirements
- R1: After a synchronous reset, clock select, interrupt mask, busy, transmit byte, receive byte, transfer flag, `irq` and `xfer_done_out` are all 0, and the control register reads 0x6D.
- R2: Register selection uses `bus_addr`: 0 is control, 1 is transmit, 2 is receive, and 3 reads 0x00. `bus_rdata` shows the selected register one clock after the address is presented. Control reads as 0x6D OR (mask << 7) OR (clock select << 4) OR (busy << 1).
- R3: A control write with bit 2 set starts a transfer only while busy is 0. Such a write sets busy and loads the countdown. The same write made while busy changes neither busy nor the countdown.
- R4: With clock select 0, completion happens at the clock edge exactly XFER_CLKS edges after the edge that accepted the start. `xfer_done_out` is high for exactly the one cycle after that edge.
- R5: On completion, busy clears and the receive register takes `peer_byte` if `peer_present` is 1, or 0x00 otherwise. `link_tx_byte` always shows the transmit register.
- R6: Completion sets the transfer flag only when the mask bit (control bit 7) is 0.
- R7: A control write with bit 7 set clears a pending transfer flag. Bit 7 also sets the mask and bit 4 sets clock select.
- R8: With clock select 1, the unit never completes by itself. It completes at the edge where `xfer_done_in` is high while busy.
- R9: `irq` is registered and equals (transfer flag OR `sig_irq_in`) as of the previous edge.
- R10: A start write issued in the cycle a transfer completes is ignored, so busy reads 0 afterwards. The next start write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| peer_present | input | 1 | A partner unit is attached |
| peer_byte | input | 8 | Partner's transmit byte |
| xfer_done_in | input | 1 | Completion strobe from the partner that drives the link clock |
| sig_irq_in | input | 1 | Companion signal-line interrupt |
| link_tx_byte | output | 8 | Local transmit byte offered to the partner |
| xfer_done_out | output | 1 | One-cycle completion strobe, shareable with the partner |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take it that every input is held at 0 during reset and is known at each rising edge. They also take it that `bus_addr` and `bus_wdata` are valid whenever `bus_wr` is high. The bench drives all inputs on falling edges, holds them idle through reset, and pulses `xfer_done_in` only while an external-mode transfer is pending. It reads outputs on the falling edge after the edge under test.

// File: rtl/link_xchg_pkg.sv
package link_xchg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TXD  = 2'd1,
    SEL_RXD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [BYTE_W-1:0] CTRL_FIXED = 8'h6D;
  localparam int BIT_MASK  = 7;
  localparam int BIT_CSEL  = 4;
  localparam int BIT_START = 2;
  localparam int BIT_BUSY  = 1;
endpackage

// File: rtl/link_xchg_timer.sv
module link_xchg_timer #(
  parameter int XFER_CLKS = 3200
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic busy,
  input  logic ext_mode,
  input  logic ext_done,
  output logic done
);
  localparam int CNT_W = $clog2(XFER_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(XFER_CLKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_INIT;
    end else if (busy && !ext_mode && cnt_q > CNT_LAST) begin
      cnt_q <= cnt_q - CNT_LAST;
    end
  end

  always_comb begin
    if (!busy) done = 1'b0;
    else if (ext_mode) done = ext_done;
    else done = (cnt_q == CNT_LAST);
  end
endmodule

// File: rtl/link_xchg_irq.sv
module link_xchg_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic sig_in,
  output logic flag,
  output logic irq
);
  logic flag_nx;

  always_comb flag_nx = (flag | set_ev) & ~clr_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nx;
      irq  <= flag_nx | sig_in;
    end
  end
endmodule

// File: rtl/link_xchg_rdmux.sv
module link_xchg_rdmux
  import link_xchg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              mask,
  input  logic              csel,
  input  logic              busy,
  input  logic [BYTE_W-1:0] txd,
  input  logic [BYTE_W-1:0] rxd,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] ctrl_view;
  logic [BYTE_W-1:0] sel_data;

  always_comb begin
    ctrl_view = CTRL_FIXED;
    ctrl_view[BIT_MASK] = mask;
    ctrl_view[BIT_CSEL] = csel;
    ctrl_view[BIT_BUSY] = busy;
  end

  always_comb begin
    unique case (reg_sel_e'(addr))
      SEL_CTRL: sel_data = ctrl_view;
      SEL_TXD:  sel_data = txd;
      SEL_RXD:  sel_data = rxd;
      default:  sel_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= sel_data;
  end
endmodule

// File: rtl/link_xchg_ctrl.sv
module link_xchg_ctrl
  import link_xchg_pkg::*;
#(
  parameter int XFER_CLKS = 3200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        peer_present,
  input  logic [7:0]  peer_byte,
  input  logic        xfer_done_in,
  input  logic        sig_irq_in,
  output logic [7:0]  link_tx_byte,
  output logic        xfer_done_out,
  output logic        irq
);
  logic              mask_q;
  logic              csel_q;
  logic              busy_q;
  logic [BYTE_W-1:0] txd_q;
  logic [BYTE_W-1:0] rxd_q;
  logic              flag_q;
  logic              ctrl_wr;
  logic              txd_wr;
  logic              start_ok;
  logic              done;

  always_comb begin
    ctrl_wr  = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL);
    txd_wr   = bus_wr && (reg_sel_e'(bus_addr) == SEL_TXD);
    start_ok = ctrl_wr && bus_wdata[BIT_START] && !busy_q && !done;
  end

  link_xchg_timer #(.XFER_CLKS(XFER_CLKS)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (start_ok),
    .busy     (busy_q),
    .ext_mode (csel_q),
    .ext_done (xfer_done_in),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q        <= 1'b0;
      csel_q        <= 1'b0;
      busy_q        <= 1'b0;
      txd_q         <= '0;
      rxd_q         <= '0;
      xfer_done_out <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mask_q <= bus_wdata[BIT_MASK];
        csel_q <= bus_wdata[BIT_CSEL];
      end
      if (txd_wr) txd_q <= bus_wdata;
      if (done) begin
        busy_q <= 1'b0;
        rxd_q  <= peer_present ? peer_byte : '0;
      end else if (start_ok) begin
        busy_q <= 1'b1;
      end
      xfer_done_out <= done;
    end
  end

  link_xchg_irq i_irq (
    .clk    (clk),
    .rst    (rst),
    .set_ev (done && !mask_q),
    .clr_ev (ctrl_wr && bus_wdata[BIT_MASK]),
    .sig_in (sig_irq_in),
    .flag   (flag_q),
    .irq    (irq)
  );

  link_xchg_rdmux i_rdmux (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .mask  (mask_q),
    .csel  (csel_q),
    .busy  (busy_q),
    .txd   (txd_q),
    .rxd   (rxd_q),
    .rdata (bus_rdata)
  );

  assign link_tx_byte = txd_q;
endmodule

// File: rtl/link_xchg_chk.sv
module link_xchg_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       peer_present,
  input logic       sig_irq_in,
  input logic       busy,
  input logic       mask,
  input logic       flag,
  input logic [7:0] rxd,
  input logic       irq,
  input logic       xfer_done_out
);
  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr && bus_addr == 2'd0 && bus_wdata[2])); // R3
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_done_out |-> (!busy && $past(busy))); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_done_out |=> !xfer_done_out); // R4
  AST_RX_NO_PEER: assert property (@(posedge clk) disable iff (rst)
    (xfer_done_out && !$past(peer_present)) |-> (rxd == 8'h00)); // R5
  AST_FLAG_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> (!$past(mask) && xfer_done_out)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == 2'd0 && bus_wdata[7]) |-> !flag); // R7
  AST_FLAG_DRIVES_IRQ: assert property (@(posedge clk) disable iff (rst)
    flag |-> irq); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag || $past(sig_irq_in))); // R9
endmodule

bind link_xchg_ctrl link_xchg_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .peer_present  (peer_present),
  .sig_irq_in    (sig_irq_in),
  .busy          (busy_q),
  .mask          (mask_q),
  .flag          (flag_q),
  .rxd           (rxd_q),
  .irq           (irq),
  .xfer_done_out (xfer_done_out)
);

// File: tb/test_link_xchg_ctrl.sv
module test_link_xchg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int XFER = 3200;
  localparam int NVEC = 5;
  // {peer_present, mask, peer_byte, tx_byte}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'hA5, 8'h3C},
    {1'b1, 1'b1, 8'h5A, 8'hC3},
    {1'b0, 1'b0, 8'hFF, 8'h81},
    {1'b1, 1'b0, 8'h00, 8'hFF},
    {1'b0, 1'b1, 8'h77, 8'h11}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic peer_present = 1'b0;
  logic [7:0] peer_byte = 8'h00;
  logic xfer_done_in = 1'b0;
  logic sig_irq_in = 1'b0;
  logic [7:0] link_tx_byte;
  logic xfer_done_out;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_xchg_ctrl #(.XFER_CLKS(XFER)) i_link_xchg_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .peer_present(peer_present), .peer_byte(peer_byte),
    .xfer_done_in(xfer_done_in), .sig_irq_in(sig_irq_in),
    .link_tx_byte(link_tx_byte), .xfer_done_out(xfer_done_out), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    ticks(CLK_PERIOD * 200000 / CLK_PERIOD);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ticks(4);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 done", {7'd0, xfer_done_out}, 8'h00);
    check("R1 tx", link_tx_byte, 8'h00);
    rd(2'd0, rv); check("R1 ctrl", rv, 8'h6D);
    rd(2'd2, rv); check("R1 rx", rv, 8'h00);

    // R2 readback of configuration bits and unused address
    wr(2'd0, 8'h90);
    rd(2'd0, rv); check("R2 ctrl mask+csel", rv, 8'hFD);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h4E);
    rd(2'd1, rv); check("R2 tx read", rv, 8'h4E);
    rd(2'd3, rv); check("R2 addr3", rv, 8'h00);

    // table walk: internal-mode transfers
    for (int v = 0; v < NVEC; v++) begin
      logic pres, msk;
      logic [7:0] pb, tb;
      {pres, msk, pb, tb} = VEC[v];
      wr(2'd0, 8'h80);
      peer_present = pres; peer_byte = pb;
      wr(2'd1, tb);
      check("R5 tx out", link_tx_byte, tb);
      wr(2'd0, {msk, 7'b0000100});
      ticks(XFER - 1);
      check("R4 not yet", {7'd0, xfer_done_out}, 8'h00);
      ticks(1);
      check("R4 done", {7'd0, xfer_done_out}, 8'h01);
      check("R6 irq", {7'd0, irq}, {7'd0, ~msk});
      rd(2'd2, rv); check("R5 rx", rv, pres ? pb : 8'h00);
      check("R4 pulse ends", {7'd0, xfer_done_out}, 8'h00);
      rd(2'd0, rv); check("R2 ctrl idle", rv, {msk, 7'h6D});
    end

    // R7 acknowledge clears flag (last vector left irq 0, make it 1)
    wr(2'd0, 8'h04);
    ticks(XFER);
    check("R7 pre irq", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h80);
    check("R7 ack", {7'd0, irq}, 8'h00);

    // R9 companion interrupt
    sig_irq_in = 1'b1;
    ticks(1);
    check("R9 sig irq", {7'd0, irq}, 8'h01);
    sig_irq_in = 1'b0;
    ticks(1);
    check("R9 sig drop", {7'd0, irq}, 8'h00);

    // R3 second start while busy ignored
    peer_present = 1'b1; peer_byte = 8'h2B;
    wr(2'd0, 8'h04);
    ticks(99);
    wr(2'd0, 8'h04);
    ticks(XFER - 101);
    check("R3 no early", {7'd0, xfer_done_out}, 8'h00);
    ticks(1);
    check("R3 original timing", {7'd0, xfer_done_out}, 8'h01);

    // R10 start in completion cycle
    peer_byte = 8'h66;
    wr(2'd0, 8'h04);
    ticks(XFER - 1);
    wr(2'd0, 8'h04);
    check("R10 done", {7'd0, xfer_done_out}, 8'h01);
    rd(2'd0, rv); check("R10 busy low", rv, 8'h6D);
    wr(2'd0, 8'h04);
    rd(2'd0, rv); check("R10 next start", rv, 8'h6F);
    ticks(XFER);

    // R8 external clock mode
    peer_byte = 8'hE1;
    wr(2'd0, 8'h94);
    begin
      int seen = 0;
      for (int i = 0; i < XFER + 200; i++) begin
        @(negedge clk);
        if (xfer_done_out) seen++;
      end
      check("R8 no self timing", seen[7:0], 8'h00);
    end
    rd(2'd0, rv); check("R8 still busy", rv, 8'hFF);
    xfer_done_in = 1'b1;
    ticks(1);
    xfer_done_in = 1'b0;
    check("R8 ext done", {7'd0, xfer_done_out}, 8'h01);
    rd(2'd2, rv); check("R8 rx", rv, 8'hE1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule